// File: doc/BRIEF.md
# External Bus Cycle Stretch Controller

This block decides, one CPU bus cycle at a time, whether an off-chip access is held for one extra E period so that a slow external peripheral has time to answer. The CPU presents each cycle at the tick that opens an E period. The cycle is described by its address, a flag that marks it as external, and the current operating mode. A small configuration register sets the policy with three bits: a stretch enable, a select that stretches every external address, and a select that picks which 8 KiB window is slowed when the stretch-all bit is clear.

All timing moves on a free-running phase tick. Each tick toggles an internal phase, and two ticks make one E period. That internal phase never pauses, so timers and serial logic that run from it are never delayed. During a stretch only two things change. The externally driven E strobe stays high for one extra period, and a stall request holds the CPU for that same period.

Top module: `bus_stretch_ctl`

## Requirements
- R1: With stretching enabled, a qualifying access is lengthened by exactly one E period (two ticks). The stall request is high for exactly two ticks, and the external strobe is high for three consecutive phases instead of one.
- R2: The internal phase output `int_e` toggles on every tick, including ticks during a stretch. No output changes on a clock edge without a tick.
- R3: When the stretch-all bit is 1, an external access at any address qualifies.
- R4: When stretch-all is 0 and the window select is 1, only external addresses 0x0000 to 0x1FFF qualify.
- R5: When stretch-all is 0 and the window select is 0, only external addresses 0xC000 to 0xDFFF qualify.
- R6: The mode encoding is 00 single-chip, 01 expanded, 10 boot, 11 test. Accesses in single-chip and boot modes are never stretched, whatever the configuration.
- R7: Reset clears all three configuration bits and drives `int_e`, `ext_e` and `cpu_stall` low. An access before the first configuration write is not stretched.
- R8: An access with `req_ext` at 0 (an internal resource) is never stretched, even inside a selected window.
- R9: The stall rises on the tick that ends the access's first E period (a tick with `int_e` high) and falls on the next such tick. Outside a stall `ext_e` equals `int_e`, and during a stall `ext_e` is high.
- R10: Address, external flag, mode and configuration are sampled only at the tick that opens the cycle, so later changes affect only later cycles. A request presented at the tick that starts a stretch is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Free-running phase tick, one per E half-period |
| req | input | 1 | A bus cycle opens at this tick |
| req_addr | input | 16 | Cycle address |
| req_ext | input | 1 | 1 when the cycle goes off-chip |
| mode | input | 2 | Operating mode (00 single, 01 expanded, 10 boot, 11 test) |
| cfg_wr | input | 1 | Load the three configuration bits |
| cfg_en | input | 1 | Stretch enable to load |
| cfg_all | input | 1 | Stretch-all select to load |
| cfg_lo | input | 1 | Window select to load (1 low window, 0 high window) |
| int_e | output | 1 | Internal E phase, never stalled |
| ext_e | output | 1 | External E strobe, stretched when needed |
| cpu_stall | output | 1 | Holds the CPU for the extra E period |

## Verification
A pending flag stuck at 1 shows up within two ticks. The stall would rise at the next period end with no qualifying cycle, and `ext_e` would then part from `int_e`. A wrong phase bit shows at once, because `ext_e` and `int_e` split outside a stall. A decoder fault only appears when the sweep reaches the mode, window and configuration that expose it. For that reason every combination is driven against window-edge addresses, and the sweep also checks the mid-cycle change and the request that arrives during a stretch.

// File: rtl/estr_pkg.sv
package estr_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } bus_mode_t;

  typedef struct packed {
    logic en;
    logic all;
    logic lo;
  } str_cfg_t;
endpackage

// File: rtl/estr_phase.sv
module estr_phase (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic ph,
  output logic per_end
);
  always_ff @(posedge clk) begin
    if (rst)       ph <= 1'b0;
    else if (tick) ph <= ~ph;
  end

  // a tick taken while the phase is high closes one E period and opens the next
  assign per_end = tick & ph;
endmodule

// File: rtl/estr_cfg.sv
module estr_cfg
  import estr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr,
  input  logic     en,
  input  logic     all,
  input  logic     lo,
  output str_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst)     cfg <= '0;
    else if (wr) cfg <= '{en: en, all: all, lo: lo};
  end
endmodule

// File: rtl/estr_qual.sv
module estr_qual
  import estr_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int WIN_W           = 3,
  parameter int LO_WIN          = 0,
  parameter int HI_WIN          = 6,
  parameter bit STRETCH_IN_TEST = 1'b1
) (
  input  str_cfg_t          cfg,
  input  logic [1:0]        mode,
  input  logic              req,
  input  logic              ext,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [WIN_W-1:0] LO_CODE = WIN_W'(LO_WIN);
  localparam logic [WIN_W-1:0] HI_CODE = WIN_W'(HI_WIN);

  bus_mode_t        m;
  logic             mode_ok;
  logic             range_ok;
  logic [WIN_W-1:0] win;

  assign m   = bus_mode_t'(mode);
  assign win = addr[ADDR_W-1 -: WIN_W];

  generate
    if (STRETCH_IN_TEST) begin : g_test_ok
      assign mode_ok = (m == MODE_EXPAND) || (m == MODE_TEST);
    end else begin : g_exp_only
      assign mode_ok = (m == MODE_EXPAND);
    end
  endgenerate

  always_comb begin
    if (cfg.all)     range_ok = 1'b1;
    else if (cfg.lo) range_ok = (win == LO_CODE);
    else             range_ok = (win == HI_CODE);
  end

  assign hit = req & ext & cfg.en & mode_ok & range_ok;
endmodule

// File: rtl/estr_seq.sv
module estr_seq (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic per_end,
  input  logic hit,
  output logic stall,
  output logic ext_e
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      stall <= 1'b0;
      ext_e <= 1'b0;
    end else if (per_end) begin
      // a pending cycle turns this period boundary into the extra period;
      // a request seen here is dropped because the CPU is being held
      stall <= pend;
      ext_e <= pend;
      pend  <= ~pend & hit;
    end else if (tick) begin
      ext_e <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_stretch_ctl.sv
module bus_stretch_ctl
  import estr_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int WIN_W           = 3,
  parameter int LO_WIN          = 0,
  parameter int HI_WIN          = 6,
  parameter bit STRETCH_IN_TEST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_ext,
  input  logic [1:0]        mode,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_all,
  input  logic              cfg_lo,
  output logic              int_e,
  output logic              ext_e,
  output logic              cpu_stall
);
  str_cfg_t cfg;
  logic     ph;
  logic     per_end;
  logic     hit;

  estr_phase u_phase (
    .clk(clk), .rst(rst), .tick(tick), .ph(ph), .per_end(per_end)
  );

  estr_cfg u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr),
    .en(cfg_en), .all(cfg_all), .lo(cfg_lo), .cfg(cfg)
  );

  estr_qual #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .LO_WIN(LO_WIN), .HI_WIN(HI_WIN),
    .STRETCH_IN_TEST(STRETCH_IN_TEST)
  ) u_qual (
    .cfg(cfg), .mode(mode), .req(req), .ext(req_ext),
    .addr(req_addr), .hit(hit)
  );

  estr_seq u_seq (
    .clk(clk), .rst(rst), .tick(tick), .per_end(per_end),
    .hit(hit), .stall(cpu_stall), .ext_e(ext_e)
  );

  assign int_e = ph;
endmodule

// File: rtl/bus_stretch_ctl_chk.sv
module bus_stretch_ctl_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic int_e,
  input logic ext_e,
  input logic cpu_stall
);
  AST_INT_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    tick |=> (int_e != $past(int_e))); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(int_e) && $stable(ext_e) && $stable(cpu_stall))); // R2
  AST_EXT_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !cpu_stall |-> (ext_e == int_e)); // R9
  AST_EXT_HELD: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> ext_e); // R9
  AST_STALL_START: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_stall) |-> $past(tick && int_e)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && !(tick && int_e)) |=> cpu_stall); // R1
  AST_STALL_END: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && tick && int_e) |=> !cpu_stall); // R1
endmodule

bind bus_stretch_ctl bus_stretch_ctl_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .int_e(int_e),
  .ext_e(ext_e), .cpu_stall(cpu_stall)
);

// File: tb/sim_bus_stretch_ctl.sv
module sim_bus_stretch_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ext = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic        cfg_wr = 1'b0, cfg_en = 1'b0, cfg_all = 1'b0, cfg_lo = 1'b0;
  logic        int_e, ext_e, cpu_stall;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  always #10 clk = ~clk;

  bus_stretch_ctl u0 (
    .clk(clk), .rst(rst), .tick(tick), .req(req), .req_addr(req_addr),
    .req_ext(req_ext), .mode(mode), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_all(cfg_all), .cfg_lo(cfg_lo), .int_e(int_e), .ext_e(ext_e),
    .cpu_stall(cpu_stall)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected<=100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one tick edge, then one idle cycle; returns at a falling edge
  task automatic pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    req  = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic e, input logic a, input logic l);
    cfg_wr = 1'b1; cfg_en = e; cfg_all = a; cfg_lo = l;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic expect_state(input string tag, input logic ie, input logic ee, input logic st);
    check({tag, " ext_e"}, 32'(ext_e), 32'(ee));
    check({tag, " cpu_stall"}, 32'(cpu_stall), 32'(st));
    check("R2 int_e", 32'(int_e), 32'(ie));
  endtask

  // runs one bus cycle opened at a period boundary and checks its timing
  task automatic access(input logic [15:0] a, input logic x, input logic [1:0] m,
                        input logic exp_str, input string tag);
    while (int_e !== 1'b1) pulse();
    req = 1'b1; req_addr = a; req_ext = x; mode = m;
    pulse();
    expect_state(tag, 1'b0, 1'b0, 1'b0);
    pulse();
    expect_state(tag, 1'b1, 1'b1, 1'b0);
    pulse();
    if (exp_str) begin
      expect_state({tag, " R1"}, 1'b0, 1'b1, 1'b1);
      pulse();
      expect_state({tag, " R1"}, 1'b1, 1'b1, 1'b1);
      pulse();
      expect_state({tag, " R9"}, 1'b0, 1'b0, 1'b0);
    end else begin
      expect_state(tag, 1'b0, 1'b0, 1'b0);
    end
  endtask

  function automatic logic model(input logic e, input logic al, input logic l,
                                 input logic [1:0] m, input logic x, input int a);
    logic in_rng;
    if (al)     in_rng = 1'b1;
    else if (l) in_rng = (a < 8192);
    else        in_rng = (a >= 49152) && (a < 57344);
    return e && x && (m == 2'd1 || m == 2'd3) && in_rng;
  endfunction

  initial begin
    logic [15:0] addrs [8];
    addrs = '{16'h0000, 16'h1FFF, 16'h2000, 16'h8000,
              16'hBFFF, 16'hC000, 16'hDFFF, 16'hE000};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_state("R7 reset", 1'b0, 1'b0, 1'b0);

    // R7: configuration starts cleared, so no stretch before a write
    access(16'hC000, 1'b1, 2'd1, 1'b0, "R7 unconfigured");
    access(16'h0000, 1'b1, 2'd3, 1'b0, "R7 unconfigured");

    for (int c = 0; c < 8; c++) begin
      write_cfg(c[2], c[1], c[0]);
      for (int m = 0; m < 4; m++) begin
        for (int x = 0; x < 2; x++) begin
          for (int k = 0; k < 8; k++) begin
            string tag;
            if (x == 0)                tag = "R8";
            else if (m == 0 || m == 2) tag = "R6";
            else if (c[1])             tag = "R3";
            else if (c[0])             tag = "R4";
            else                       tag = "R5";
            access(addrs[k], x[0], m[1:0],
                   model(c[2], c[1], c[0], m[1:0], x[0], int'(addrs[k])), tag);
          end
        end
      end
    end

    // R10: disable after the opening tick; the cycle still stretches
    write_cfg(1'b1, 1'b1, 1'b0);
    while (int_e !== 1'b1) pulse();
    req = 1'b1; req_addr = 16'h4000; req_ext = 1'b1; mode = 2'd1;
    pulse();
    write_cfg(1'b0, 1'b0, 1'b0);
    mode = 2'd0;
    pulse();
    pulse();
    check("R10 late disable stall", 32'(cpu_stall), 32'd1);
    pulse(); pulse();
    check("R10 late disable end", 32'(cpu_stall), 32'd0);
    access(16'h4000, 1'b1, 2'd1, 1'b0, "R10 next cycle uses new cfg");

    // R10: enable after the opening tick; that cycle is not stretched
    while (int_e !== 1'b1) pulse();
    req = 1'b1; req_addr = 16'hC100; req_ext = 1'b1; mode = 2'd1;
    pulse();
    write_cfg(1'b1, 1'b0, 1'b0);
    pulse();
    pulse();
    check("R10 late enable", 32'(cpu_stall), 32'd0);
    access(16'hC100, 1'b1, 2'd1, 1'b1, "R10 following cycle");

    // R10: request presented at the tick that starts a stretch is ignored
    while (int_e !== 1'b1) pulse();
    req = 1'b1; req_addr = 16'hC000; req_ext = 1'b1; mode = 2'd1;
    pulse();
    pulse();
    req = 1'b1; req_addr = 16'hC000; req_ext = 1'b1;
    pulse();
    check("R10 stretch begins", 32'(cpu_stall), 32'd1);
    pulse(); pulse();
    check("R10 stretch over", 32'(cpu_stall), 32'd0);
    pulse(); pulse();
    check("R10 ignored request", 32'(cpu_stall), 32'd0);
    check("R10 ignored request ext_e", 32'(ext_e), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule